// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Pin-Control Decoder

This block is a boundary-scan test access port for a chip. A 16-state controller advances on the rising edge of TCK under TMS. It drives a 10-bit instruction register and one of four data registers, which sit between TDI and TDO:

- a 1-bit bypass stage;
- a 32-bit identification word;
- a 32-bit user word;
- a boundary chain of parameterised length that captures the chip's input pins.

TDO is launched on the falling edge of TCK. TDO is enabled only while a register is shifting.

The active instruction also drives the chip's pin-control signals:

- a global output disable;
- a select that replaces the functional output values with the boundary update latches;
- a one-cycle reconfiguration request.

The chip's I/O ring uses these signals directly. The update latch contents appear on `scan_data`.

The controller has these states:

- Test-Logic-Reset (TLR)
- Run-Test/Idle (RTI)
- Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR
- Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR

Transitions with TMS=1 / TMS=0:

| State | TMS=1 | TMS=0 |
|---|---|---|
| TLR | TLR | RTI |
| RTI | Select-DR | RTI |
| Select-DR | Select-IR | Capture-DR |
| Capture-DR | Exit1-DR | Shift-DR |
| Shift-DR | Exit1-DR | Shift-DR |
| Exit1-DR | Update-DR | Pause-DR |
| Pause-DR | Exit2-DR | Pause-DR |
| Exit2-DR | Update-DR | Shift-DR |
| Update-DR | Select-DR | RTI |
| Select-IR | TLR | Capture-IR |

The IR side (Capture-IR through Update-IR) mirrors the DR side.

Top module: `tap_unit`

## Requirements
- R1: The controller moves on each rising TCK edge through the 16 states listed above. Five consecutive rising edges with TMS=1 always leave it in Test-Logic-Reset. An active-low `trst_n` forces Test-Logic-Reset asynchronously.
- R2: After reset, the active instruction is IDCODE. While the controller stays in Test-Logic-Reset, every rising edge reloads IDCODE. With IDCODE active, `io_disable`, `scan_sel` and `reconfig_req` are all low.
- R3: In Capture-IR the instruction shift register loads 10'b00_0000_0001. This pattern is shifted out least significant bit first in the following Shift-IR.
- R4: The instruction is 10 bits, shifted in least significant bit first. It becomes active on the rising edge that leaves Update-IR.
- R5: IDCODE (10'h006) selects the 32-bit identification word (parameter `ID_CODE`), which is shifted out LSB first.
- R6: USERCODE (10'h007) selects the 32-bit user word (parameter `USER_CODE`), which is shifted out LSB first.
- R7: BYPASS (10'h3FF) selects the 1-bit bypass stage, and so does every opcode not listed in these requirements. The bypass stage captures 0, so TDO shows TDI delayed by one bit. Pin controls stay low.
- R8: SAMPLE/PRELOAD (10'h005) selects the boundary chain. Capture-DR loads `pin_in`, and bit i of the chain drives TDO in shift position i. Update-DR copies the chain into `scan_data`. `scan_sel` stays low. The update latch changes only in Update-DR, and only while SAMPLE/PRELOAD or EXTEST is active.
- R9: EXTEST (10'h00F) selects the boundary chain and raises `scan_sel`. Capture-DR samples `pin_in`, and Update-DR refreshes `scan_data`.
- R10: HIGHZ (10'h00B) raises `io_disable`, keeps `scan_sel` low and selects the bypass stage.
- R11: CLAMP (10'h00A) raises `scan_sel` and selects the bypass stage. `scan_data` keeps its latched value through a DR scan.
- R12: The reconfiguration instruction (10'h001) selects the bypass stage. It raises `reconfig_req` on the edge that leaves Update-IR, for exactly one TCK cycle.
- R13: `tdo` and `tdo_en` change only on the falling TCK edge. `tdo_en` is high only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (tie high if unused) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BSR_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge launched |
| tdo_en | output | 1 | TDO output enable |
| io_disable | output | 1 | Global output disable (tri-state all I/O) |
| scan_sel | output | 1 | Drive outputs from `scan_data` instead of functional values |
| scan_data | output | BSR_LEN | Boundary update latch contents |
| reconfig_req | output | 1 | One-cycle reconfiguration request |

## Verification
The embedded assertions check several behaviours on every cycle:

- five TMS-high edges reach Test-Logic-Reset;
- Capture-IR leaves the fixed pattern in the shift register;
- Test-Logic-Reset restores IDCODE;
- `reconfig_req` never lasts beyond one cycle;
- `io_disable` and `scan_sel` are never high together;
- `tdo_en` is confined to the shift states;
- the update latch moves only after Update-DR.

The directed scenarios are needed for the data-path content. They show the exact ID and user words, the one-bit bypass delay for listed and unlisted opcodes, pin capture and preload under SAMPLE/PRELOAD and EXTEST, and CLAMP holding the latch through a scan. They also show the falling-edge timing of `tdo_en`.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int IR_W   = 10;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SCAN, ST_DR_CAPTURE, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPDATE,
        ST_IR_SCAN, ST_IR_CAPTURE, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPDATE
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_USER, DR_BOUNDARY} dr_sel_e;

    localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
    localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
    localparam logic [IR_W-1:0] OP_BYPASS   = 10'h3FF;
    localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
    localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
    localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
    localparam logic [IR_W-1:0] OP_RECONFIG = 10'h001;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 10'h001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_RESET:      nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:       nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            ST_DR_SCAN:    nxt = tms ? ST_IR_SCAN  : ST_DR_CAPTURE;
            ST_DR_CAPTURE: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1:   nxt = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2:   nxt = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            ST_IR_SCAN:    nxt = tms ? ST_RESET    : ST_IR_CAPTURE;
            ST_IR_CAPTURE: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1:   nxt = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2:   nxt = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            ST_IR_UPDATE:  nxt = tms ? ST_DR_SCAN  : ST_IDLE;
            default:       nxt = ST_RESET;
        endcase
    end

    // Run length of consecutive TMS-high edges, saturating at five (checks R1)
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             ones_q <= 3'd0;
        else if (!tms)           ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (state == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output dr_sel_e    dr_sel,
    output logic       io_disable,
    output logic       scan_sel,
    output logic       reconfig_req
);
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] active;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr        <= IR_CAPTURE;
            active       <= OP_IDCODE;
            reconfig_req <= 1'b0;
        end else begin
            if (state == ST_IR_CAPTURE)    ir_sr <= IR_CAPTURE;
            else if (state == ST_IR_SHIFT) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

            if (state == ST_RESET)          active <= OP_IDCODE;
            else if (state == ST_IR_UPDATE) active <= ir_sr;

            reconfig_req <= (state == ST_IR_UPDATE) && (ir_sr == OP_RECONFIG);
        end
    end

    assign ir_lsb = ir_sr[0];

    always_comb begin
        dr_sel     = DR_BYPASS;
        io_disable = 1'b0;
        scan_sel   = 1'b0;
        unique case (active)
            OP_IDCODE:   dr_sel = DR_IDENT;
            OP_USERCODE: dr_sel = DR_USER;
            OP_SAMPLE:   dr_sel = DR_BOUNDARY;
            OP_EXTEST: begin
                dr_sel   = DR_BOUNDARY;
                scan_sel = 1'b1;
            end
            OP_HIGHZ:    io_disable = 1'b1;
            OP_CLAMP:    scan_sel   = 1'b1;
            default:     dr_sel = DR_BYPASS;
        endcase
    end

    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAPTURE) |=> (ir_sr == IR_CAPTURE));
    a_r2_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (active == OP_IDCODE));
    a_r12_single_pulse: assert property (@(posedge tck) disable iff (!trst_n)
        reconfig_req |=> !reconfig_req);
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int               BSR_LEN   = 8,
    parameter logic [WORD_W-1:0] ID_CODE   = 32'h0A5C_10DD,
    parameter logic [WORD_W-1:0] USER_CODE = 32'hC0DE_7731
) (
    input  logic               tck,
    input  logic               trst_n,
    input  tap_state_e         state,
    input  logic               tdi,
    input  dr_sel_e            dr_sel,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_upd
);
    logic              byp;
    logic [WORD_W-1:0] word_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic [BSR_LEN:0]   chain;
    logic              bnd;

    assign bnd                 = (dr_sel == DR_BOUNDARY);
    assign chain[BSR_LEN]      = tdi;
    assign chain[BSR_LEN-1:0]  = bsr_sr;

    // Bypass stage and shared 32-bit word register (ID or user code)
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp     <= 1'b0;
            word_sr <= '0;
        end else if (state == ST_DR_CAPTURE) begin
            byp     <= 1'b0;
            word_sr <= (dr_sel == DR_USER) ? USER_CODE : ID_CODE;
        end else if (state == ST_DR_SHIFT) begin
            byp     <= tdi;
            word_sr <= {tdi, word_sr[WORD_W-1:1]};
        end
    end

    // Boundary chain: one capture/shift cell per pin
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                              bsr_sr[i] <= 1'b0;
            else if (bnd && state == ST_DR_CAPTURE)   bsr_sr[i] <= pin_in[i];
            else if (bnd && state == ST_DR_SHIFT)     bsr_sr[i] <= chain[i+1];
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                            bsr_upd <= '0;
        else if (bnd && state == ST_DR_UPDATE)  bsr_upd <= bsr_sr;
    end

    always_comb begin
        unique case (dr_sel)
            DR_IDENT, DR_USER: dr_lsb = word_sr[0];
            DR_BOUNDARY:       dr_lsb = bsr_sr[0];
            default:           dr_lsb = byp;
        endcase
    end

    a_r8_update_only_in_update_dr: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(bsr_upd) |-> ($past(state) == ST_DR_UPDATE));
endmodule

// File: rtl/tap_unit.sv
module tap_unit
    import tap_pkg::*;
#(
    parameter int          BSR_LEN   = 8,
    parameter logic [31:0] ID_CODE   = 32'h0A5C_10DD,
    parameter logic [31:0] USER_CODE = 32'hC0DE_7731
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               io_disable,
    output logic               scan_sel,
    output logic [BSR_LEN-1:0] scan_data,
    output logic               reconfig_req
);
    tap_state_e state;
    dr_sel_e    dr_sel;
    logic       ir_lsb;
    logic       dr_lsb;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck          (tck),
        .trst_n       (trst_n),
        .state        (state),
        .tdi          (tdi),
        .ir_lsb       (ir_lsb),
        .dr_sel       (dr_sel),
        .io_disable   (io_disable),
        .scan_sel     (scan_sel),
        .reconfig_req (reconfig_req)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE), .USER_CODE(USER_CODE)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .tdi     (tdi),
        .dr_sel  (dr_sel),
        .pin_in  (pin_in),
        .dr_lsb  (dr_lsb),
        .bsr_upd (scan_data)
    );

    // TDO and its enable are launched on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
            if (state == ST_IR_SHIFT)      tdo <= ir_lsb;
            else if (state == ST_DR_SHIFT) tdo <= dr_lsb;
            else                           tdo <= 1'b0;
        end
    end

    a_r13_tdo_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));
    a_r13_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);
    a_r10_disable_excludes_scan: assert property (@(posedge tck) disable iff (!trst_n)
        io_disable |-> !scan_sel);
endmodule

// File: tb/tap_unit_test.sv
module tap_unit_test;
    localparam int          BSR_LEN = 8;
    localparam logic [31:0] ID_W    = 32'h0A5C_10DD;
    localparam logic [31:0] USER_W  = 32'hC0DE_7731;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BSR_LEN-1:0] pin_in = '0;
    logic tdo, tdo_en, io_disable, scan_sel, reconfig_req;
    logic [BSR_LEN-1:0] scan_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic en_ok;

    tap_unit #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_W), .USER_CODE(USER_W)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .io_disable(io_disable), .scan_sel(scan_sel),
        .scan_data(scan_data), .reconfig_req(reconfig_req)
    );

    always #4 tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample TDO after the falling edge, then drive TMS/TDI for the next rising edge
    task automatic clk_bit(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo;
        tms = m;
        tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic shift_ir(input logic [9:0] code, output logic [9:0] cap);
        logic o;
        clk_bit(1, 0, o); clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
        for (int i = 0; i < 10; i++) begin
            clk_bit(i == 9, code[i], o);
            cap[i] = o;
        end
        clk_bit(1, 0, o);
        clk_bit(0, 0, o);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout  = '0;
        en_ok = 1'b1;
        clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
        for (int i = 0; i < n; i++) begin
            clk_bit(i == n - 1, din[i], o);
            dout[i] = o;
            if (tdo_en !== 1'b1) en_ok = 1'b0;
        end
        clk_bit(1, 0, o);
        clk_bit(0, 0, o);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        logic o;
        trst_n = 1'b0;
        #20;
        chk("R2 io_disable in reset", io_disable, 0);
        chk("R2 scan_sel in reset", scan_sel, 0);
        chk("R2 reconfig_req in reset", reconfig_req, 0);
        chk("R13 tdo_en in reset", tdo_en, 0);
        trst_n = 1'b1;
        clk_bit(0, 0, o);
        shift_dr(32, 0, d);
        chk("R2 R5 IDCODE after reset", d[31:0], ID_W);
    endtask

    task automatic t_ir_capture_user();
        logic [9:0] cap;
        logic [63:0] d;
        shift_ir(10'h007, cap);
        chk("R3 capture pattern", cap, 10'h001);
        shift_dr(32, 0, d);
        chk("R4 R6 USERCODE word", d[31:0], USER_W);
        chk("R13 tdo_en during shift", en_ok, 1);
    endtask

    task automatic t_idcode();
        logic [9:0] cap;
        logic [63:0] d;
        shift_ir(10'h006, cap);
        shift_dr(32, 0, d);
        chk("R5 IDCODE word", d[31:0], ID_W);
    endtask

    task automatic t_bypass(input logic [9:0] op, input string req);
        logic [9:0] cap;
        logic [63:0] d;
        shift_ir(op, cap);
        shift_dr(8, 64'hA5, d);
        chk(req, d[7:0], 8'h4A);
        chk("R7 pins normal in bypass", {io_disable, scan_sel}, 2'b00);
    endtask

    task automatic t_sample_extest();
        logic [9:0] cap;
        logic [63:0] d;
        pin_in = 8'h3C;
        shift_ir(10'h005, cap);
        chk("R8 scan_sel low in SAMPLE", scan_sel, 0);
        shift_dr(8, 64'h96, d);
        chk("R8 pin capture", d[7:0], 8'h3C);
        chk("R8 preload latched", scan_data, 8'h96);
        shift_ir(10'h00F, cap);
        chk("R9 scan_sel in EXTEST", scan_sel, 1);
        chk("R9 latch held by IR scan", scan_data, 8'h96);
        pin_in = 8'h81;
        shift_dr(8, 64'h5A, d);
        chk("R9 EXTEST capture", d[7:0], 8'h81);
        chk("R9 EXTEST update", scan_data, 8'h5A);
    endtask

    task automatic t_clamp();
        logic [9:0] cap;
        logic [63:0] d;
        shift_ir(10'h00A, cap);
        chk("R11 scan_sel in CLAMP", scan_sel, 1);
        chk("R11 io_disable low in CLAMP", io_disable, 0);
        shift_dr(8, 64'hF0, d);
        chk("R11 bypass in CLAMP", d[7:0], 8'hE0);
        chk("R11 latch held", scan_data, 8'h5A);
    endtask

    task automatic t_highz();
        logic [9:0] cap;
        logic [63:0] d;
        shift_ir(10'h00B, cap);
        chk("R10 io_disable in HIGHZ", io_disable, 1);
        chk("R10 scan_sel low in HIGHZ", scan_sel, 0);
        shift_dr(8, 64'h33, d);
        chk("R10 bypass in HIGHZ", d[7:0], 8'h66);
    endtask

    task automatic t_reconfig();
        logic [9:0] cap;
        logic [63:0] d;
        logic o;
        chk("R12 idle before", reconfig_req, 0);
        shift_ir(10'h001, cap);
        chk("R12 pulse high", reconfig_req, 1);
        clk_bit(0, 0, o);
        chk("R12 pulse one cycle", reconfig_req, 0);
        shift_dr(8, 64'h01, d);
        chk("R12 bypass selected", d[7:0], 8'h02);
        chk("R12 no further pulse", reconfig_req, 0);
    endtask

    task automatic t_five_ones();
        logic [9:0] cap;
        logic [63:0] d;
        logic o;
        shift_ir(10'h00F, cap);
        clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
        for (int i = 0; i < 5; i++) clk_bit(1, 0, o);
        clk_bit(0, 0, o);
        chk("R1 R2 reset via TMS, EXTEST dropped", scan_sel, 0);
        shift_dr(32, 0, d);
        chk("R1 IDCODE after TMS reset", d[31:0], ID_W);
    endtask

    task automatic t_tdo_timing();
        logic [9:0] cap;
        logic o;
        shift_ir(10'h006, cap);
        clk_bit(1, 0, o); clk_bit(0, 0, o); clk_bit(0, 0, o);
        chk("R13 tdo_en waits for falling edge", tdo_en, 0);
        @(negedge tck); #1;
        chk("R13 tdo_en after falling edge", tdo_en, 1);
        chk("R13 first TDO bit", tdo, ID_W[0]);
        clk_bit(0, 0, o);
        clk_bit(1, 0, o);
        clk_bit(1, 0, o);
        clk_bit(0, 0, o);
        clk_bit(0, 0, o);
        chk("R13 tdo_en low in idle", tdo_en, 0);
        chk("R13 tdo low in idle", tdo, 0);
    endtask

    initial begin
        t_reset();
        t_ir_capture_user();
        t_idcode();
        t_bypass(10'h3FF, "R7 BYPASS delay");
        t_bypass(10'h0C3, "R7 unused opcode acts as bypass");
        t_sample_extest();
        t_clamp();
        t_highz();
        t_reconfig();
        t_five_ones();
        t_tdo_timing();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule